// File: doc/BRIEF.md
# Gain-Code Controller with Serial and Parallel Loading

This block keeps the 4-bit gain code of a programmable-gain amplifier and lets a host set it in one of two ways. With the mode input high, four parallel lines supply the code, and a hold control either passes them through continuously or freezes the code. With the mode input low, a chip-select framed serial port shifts bytes in most significant bit first, and commits the low nibble of the byte when chip-select returns high. A daisy-chain output returns the byte that was loaded before, one bit per serial clock.

One pad is shared between the two interfaces. In parallel mode it carries parallel bit 3 into the block. In serial mode it carries the daisy-chain output, and the block drives its output enable. Every pin input is sampled on the system clock through a two-stage synchroniser, and serial clock and chip-select edges are found from the synchronised values. Codes 14 and 15 are not valid gain settings. They are refused: the code already held is kept and an error flag is raised.

Top module: `gain_code_ctrl`

## Requirements
- R1: While rst_n is low and after its release, gain_code is 0, code_err is 0, dq3_out is 0 and dq3_oe is 0.
- R2: par_sel high selects parallel mode, with dq3_oe low. par_sel low selects serial mode, with dq3_oe high. dq3_oe follows a change of par_sel after 2 clock edges. In parallel mode dq3_out does not change.
- R3: In parallel mode with hold_en low, the code {dq3_in, par_d[2:0]} (dq3_in is bit 3) is applied to gain_code on every cycle.
- R4: In parallel mode with hold_en high, gain_code and code_err keep their values whatever happens on dq3_in and par_d.
- R5: In serial mode with cs_n low, each rising edge of sclk shifts sdi into bit 0 of an 8-bit register, and the older contents move one place toward bit 7, so the first bit sent ends in bit 7.
- R6: A rising edge of cs_n in serial mode applies register bits [3:0] as the new code. Bits [7:4] have no effect on gain_code.
- R7: In serial mode, dq3_out is loaded with register bit 7 on the falling edge of cs_n and on each falling edge of sclk while cs_n is low. During a transfer it therefore returns the previous byte, most significant bit first.
- R8: sclk edges while cs_n is high do not alter the register. When cs_n falls while sclk is high, no extra shift occurs.
- R9: The valid codes are 0 to 13. Applying 14 or 15 leaves gain_code unchanged and sets code_err. Applying a valid code loads it and clears code_err.
- R10: Each pin input passes through two synchroniser flip-flops. A parallel code change, a cs_n rise, an sclk rise or an sclk fall produces its result at the third clock edge after the input changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_sel | input | 1 | 1 selects parallel mode, 0 selects serial mode |
| hold_en | input | 1 | Parallel mode: 1 freezes the code, 0 passes it through |
| par_d | input | 3 | Parallel code bits 2..0 |
| dq3_in | input | 1 | Shared pad input, parallel code bit 3 |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| cs_n | input | 1 | Serial chip-select, active low |
| gain_code | output | 4 | Applied gain code |
| code_err | output | 1 | Last applied code was outside 0..13 |
| dq3_out | output | 1 | Shared pad output, serial daisy-chain data |
| dq3_oe | output | 1 | Output enable of the shared pad |

## Verification
A parallel code change shows on gain_code at the third clock edge after it is driven. A cs_n rise commits at the third edge, and dq3_out follows an sclk fall or a cs_n fall at the third edge, while dq3_oe follows par_sel at the second. The bench drives inputs on falling clock edges. A behavioural model sees each input through a three-deep sample queue and is compared with every output on every falling edge. Directed checks look at gain_code exactly two and three edges after a parallel change to pin the latency. The serial tasks wait at least four edges after each sclk or cs_n change before they read dq3_out or gain_code.

// File: rtl/gcc_pkg.sv
package gcc_pkg;
    localparam int CODE_W    = 4;
    localparam int SR_W      = 8;
    localparam int NUM_GAINS = 14;

    typedef logic [CODE_W-1:0] gain_t;

    function automatic logic code_ok(input gain_t code);
        return int'(code) < NUM_GAINS;
    endfunction
endpackage

// File: rtl/gcc_sync.sv
module gcc_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
    } sync_st_t;

    localparam sync_st_t RST_STATE = '{pipe: {STAGES{RST_VAL}}};

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_STATE;
        else        st_q <= st_d;
    end

    assign dout = st_q.pipe[STAGES-1];
endmodule

// File: rtl/gcc_serial.sv
module gcc_serial
    import gcc_pkg::*;
#(
    parameter int SHIFT_W = SR_W
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en_i,
    input  logic  sclk_s,
    input  logic  sdi_s,
    input  logic  csn_s,
    output logic  dout_o,
    output logic  commit_o,
    output gain_t code_o
);
    typedef struct packed {
        logic [SHIFT_W-1:0] sr;
        logic               dout;
        logic               sclk_p;
        logic               csn_p;
    } ser_st_t;

    localparam ser_st_t RST_STATE = '{sr: '0, dout: 1'b0, sclk_p: 1'b0, csn_p: 1'b1};

    ser_st_t st_d, st_q;
    logic    active, sclk_rise, sclk_fall, cs_fall, cs_rise;

    always_comb begin
        active    = en_i && !csn_s;
        sclk_rise = sclk_s && !st_q.sclk_p;
        sclk_fall = !sclk_s && st_q.sclk_p;
        cs_fall   = !csn_s && st_q.csn_p;
        cs_rise   = csn_s && !st_q.csn_p;

        st_d        = st_q;
        st_d.sclk_p = sclk_s;
        st_d.csn_p  = csn_s;
        if (active && sclk_rise) begin
            st_d.sr = {st_q.sr[SHIFT_W-2:0], sdi_s};
        end
        if (active && (sclk_fall || cs_fall)) begin
            st_d.dout = st_q.sr[SHIFT_W-1];
        end

        commit_o = en_i && cs_rise;
        code_o   = st_q.sr[CODE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_STATE;
        else        st_q <= st_d;
    end

    assign dout_o = st_q.dout;

    // R5: a qualified rising edge lands the data bit in the lowest position
    assert_shift_in_lsb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && sclk_rise) |=> (st_q.sr[0] == $past(sdi_s)));

    // R8: a deselected port keeps its register contents
    assert_idle_when_deselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> $stable(st_q.sr));
endmodule

// File: rtl/gcc_gain.sv
module gcc_gain
    import gcc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_i,
    input  gain_t code_i,
    output gain_t gain_o,
    output logic  err_o
);
    typedef struct packed {
        gain_t gain;
        logic  err;
    } gain_st_t;

    gain_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            if (code_ok(code_i)) begin
                st_d.gain = code_i;
                st_d.err  = 1'b0;
            end else begin
                st_d.err  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gain_o = st_q.gain;
    assign err_o  = st_q.err;

    // R9: a refused code leaves the applied code untouched
    assert_keep_on_bad_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !code_ok(code_i)) |=> ($stable(st_q.gain) && st_q.err));

    // R9: the held code is always a valid setting
    assert_gain_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        code_ok(st_q.gain));

    // R4: without a load request nothing moves
    assert_quiet_without_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(st_q.gain) && $stable(st_q.err)));
endmodule

// File: rtl/gain_code_ctrl.sv
module gain_code_ctrl
    import gcc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       par_sel,
    input  logic       hold_en,
    input  logic [2:0] par_d,
    input  logic       dq3_in,
    input  logic       sclk,
    input  logic       sdi,
    input  logic       cs_n,
    output logic [3:0] gain_code,
    output logic       code_err,
    output logic       dq3_out,
    output logic       dq3_oe
);
    typedef struct packed {
        logic  mode;
        logic  hold;
        gain_t pcode;
        logic  sclk;
        logic  sdi;
        logic  csn;
    } pins_t;

    localparam int    PINS_W   = $bits(pins_t);
    localparam pins_t PINS_RST = '{mode: 1'b1, hold: 1'b0, pcode: '0,
                                   sclk: 1'b0, sdi: 1'b0, csn: 1'b1};

    pins_t raw, syn;
    logic  ser_commit, ser_dout;
    gain_t ser_code;
    logic  load;
    gain_t load_code;
    gain_t gain_q;
    logic  err_q;

    assign raw = '{mode: par_sel, hold: hold_en, pcode: {dq3_in, par_d},
                   sclk: sclk, sdi: sdi, csn: cs_n};

    gcc_sync #(
        .W       (PINS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PINS_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw),
        .dout  (syn)
    );

    gcc_serial #(
        .SHIFT_W (SR_W)
    ) u_serial (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (!syn.mode),
        .sclk_s   (syn.sclk),
        .sdi_s    (syn.sdi),
        .csn_s    (syn.csn),
        .dout_o   (ser_dout),
        .commit_o (ser_commit),
        .code_o   (ser_code)
    );

    always_comb begin
        if (syn.mode) begin
            load      = !syn.hold;
            load_code = syn.pcode;
        end else begin
            load      = ser_commit;
            load_code = ser_code;
        end
    end

    gcc_gain u_gain (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .code_i (load_code),
        .gain_o (gain_q),
        .err_o  (err_q)
    );

    assign gain_code = gain_q;
    assign code_err  = err_q;
    assign dq3_out   = ser_dout;
    assign dq3_oe    = !syn.mode;

    // R4: held parallel code is frozen
    assert_hold_freezes_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (syn.mode && syn.hold) |=> $stable(gain_q));

    // R2: the shared pad output does not move in parallel mode
    assert_pad_quiet_in_parallel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        syn.mode |=> $stable(ser_dout));
endmodule

// File: tb/sim_gain_code_ctrl.sv
`timescale 1ns/1ps
module sim_gain_code_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       par_sel = 1'b1, hold_en = 1'b0, dq3_in = 1'b0, sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1;
    logic [2:0] par_d = 3'd0;
    logic [3:0] gain_code;
    logic       code_err, dq3_out, dq3_oe;

    int checks = 0, failures = 0, cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gain_code_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .par_sel(par_sel), .hold_en(hold_en), .par_d(par_d),
        .dq3_in(dq3_in), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
        .gain_code(gain_code), .code_err(code_err), .dq3_out(dq3_out), .dq3_oe(dq3_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: sample vector {mode,hold,d3,pd[2:0],sclk,sdi,csn}
    localparam logic [8:0] IDLE_VEC = 9'b1_0_0_000_0_0_1;
    logic [8:0] hq[$];
    int  m_gain = 0, m_sr = 0;
    bit  m_err = 0, m_dout = 0;

    function automatic void apply_code(input int c);
        if (c <= 13) begin m_gain = c; m_err = 0; end
        else m_err = 1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hq = {IDLE_VEC, IDLE_VEC, IDLE_VEC};
            m_gain = 0; m_err = 0; m_sr = 0; m_dout = 0;
        end else begin
            logic [8:0] cur, old;
            int sr_before;
            cur = hq[1]; old = hq[0];
            sr_before = m_sr;
            if (cur[8]) begin
                if (!cur[7]) apply_code(int'(cur[6:3]));
            end else begin
                if (cur[0] && !old[0]) apply_code(sr_before & 15);
                if (!cur[0]) begin
                    if (cur[2] && !old[2]) m_sr = ((sr_before << 1) | int'(cur[1])) & 255;
                    if ((!cur[2] && old[2]) || old[0]) m_dout = sr_before[7];
                end
            end
            void'(hq.pop_front());
            hq.push_back({par_sel, hold_en, dq3_in, par_d, sclk, sdi, cs_n});
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3/R6/R9 model gain_code", int'(gain_code), m_gain);
            chk("R9 model code_err", int'(code_err), int'(m_err));
            chk("R7 model dq3_out", int'(dq3_out), int'(m_dout));
            chk("R2 model dq3_oe", int'(dq3_oe), int'(!hq[1][8]));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL R10 watchdog actual=%0d expected<=100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_par(input int c);
        dq3_in = c[3];
        par_d  = c[2:0];
    endtask

    task automatic send_byte(input logic [7:0] b, input bit pre_high, output logic [7:0] rx);
        if (pre_high) begin
            sclk = 1'b1; tick(4);
            cs_n = 1'b0; tick(4);
            sclk = 1'b0; tick(4);
        end else begin
            cs_n = 1'b0; tick(4);
        end
        for (int i = 7; i >= 0; i--) begin
            sdi = b[i]; tick(2);
            rx[i] = dq3_out;
            sclk = 1'b1; tick(4);
            sclk = 1'b0; tick(2);
        end
        cs_n = 1'b1; tick(6);
    endtask

    initial begin
        logic [7:0] rx;
        tick(2);
        chk("R1 reset gain_code", int'(gain_code), 0);
        chk("R1 reset code_err", int'(code_err), 0);
        chk("R1 reset dq3_out", int'(dq3_out), 0);
        chk("R1 reset dq3_oe", int'(dq3_oe), 0);
        rst_n = 1'b1;
        tick(4);
        chk("R1 after release gain_code", int'(gain_code), 0);

        // R3 and R10: pass-through with exact latency
        set_par(5); tick(2);
        chk("R10 gain not yet at edge 2", int'(gain_code), 0);
        tick(1);
        chk("R10 R3 gain at edge 3", int'(gain_code), 5);
        set_par(11); tick(3);
        chk("R3 pass-through 11 with bit 3 from dq3_in", int'(gain_code), 11);

        // R9: refused parallel code
        set_par(15); tick(3);
        chk("R9 code 15 flagged", int'(code_err), 1);
        chk("R9 code 15 keeps gain", int'(gain_code), 11);
        set_par(9); tick(3);
        chk("R9 valid code clears flag", int'(code_err), 0);
        chk("R9 valid code loaded", int'(gain_code), 9);

        // R4: hold freezes
        hold_en = 1'b1; tick(3);
        set_par(3); tick(5);
        chk("R4 held gain ignores inputs", int'(gain_code), 9);
        set_par(14); tick(5);
        chk("R4 held flag ignores bad code", int'(code_err), 0);
        hold_en = 1'b0; set_par(3); tick(4);
        chk("R3 release of hold passes code", int'(gain_code), 3);

        // R2: mode switch
        chk("R2 parallel oe low", int'(dq3_oe), 0);
        par_sel = 1'b0; tick(1);
        chk("R2 oe unchanged after 1 edge", int'(dq3_oe), 0);
        tick(1);
        chk("R2 serial oe high after 2 edges", int'(dq3_oe), 1);
        set_par(12); tick(4);
        chk("R2 parallel lines ignored in serial mode", int'(gain_code), 3);

        // R5 R6 R7: serial loading and daisy chain
        send_byte(8'hA7, 0, rx);
        chk("R6 low nibble of A7 applied", int'(gain_code), 7);
        chk("R7 first transfer returns reset byte", int'(rx), 0);
        send_byte(8'h3C, 0, rx);
        chk("R5 R6 low nibble of 3C applied", int'(gain_code), 12);
        chk("R7 daisy chain returns A7", int'(rx), 8'hA7);
        send_byte(8'h0E, 0, rx);
        chk("R9 serial code 14 flagged", int'(code_err), 1);
        chk("R9 serial code 14 keeps gain", int'(gain_code), 12);
        chk("R7 daisy chain returns 3C", int'(rx), 8'h3C);

        // R8: clocks while deselected, and chip-select falling with clock high
        sdi = 1'b1;
        for (int k = 0; k < 3; k++) begin
            sclk = 1'b1; tick(4);
            sclk = 1'b0; tick(4);
        end
        chk("R8 no commit from deselected clocks", int'(gain_code), 12);
        send_byte(8'h05, 1, rx);
        chk("R8 register untouched while deselected", int'(rx), 8'h0E);
        chk("R8 no extra shift at select with clock high", int'(gain_code), 5);
        chk("R9 flag cleared by valid serial code", int'(code_err), 0);
        send_byte(8'hF2, 0, rx);
        chk("R6 upper nibble ignored", int'(gain_code), 2);
        chk("R7 daisy chain returns 05", int'(rx), 8'h05);

        tick(4);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule